// File: doc/BRIEF.md
# Gather Descriptor Copy Engine

This block moves data between buffers held in a word-wide memory. Software lays out a source ring of 8-byte descriptors, each naming a buffer by byte address together with a byte count and a flag field. It also posts empty destination buffers on a second ring. Software then raises each ring's write index. The engine walks the source ring from its read index up to the software write index. It copies every fragment's words into the buffer named by the oldest posted destination descriptor.

A fragment whose gather flag is set does not close the transfer. The next fragment lands directly after it in the same destination buffer, and this continues until a fragment with gather clear is copied. The engine then writes the total length and a result flag field back into the destination descriptor's second word. It advances the destination read index and pulses copy complete. Each fragment may ask for its words to be byte-reversed. A 14-bit transfer identifier travels from the closing fragment to the destination descriptor. Data that would run past the configured maximum destination length is not written, and the overrun is flagged.

Both ring and data accesses share one memory port. Read data on that port is due one cycle after the request. A halt input parks the engine between descriptors.

Top module: `ce_copy_engine`

## Requirements
- R1: A ring entry at index i occupies words base+2i (buffer byte address; the word address is bits [AW+1:2]) and base+2i+1 (byte count in bits [15:0], flags in bits [31:16]). Flag bit 0 is gather, flag bit 1 is byte swap, and flag bits [15:2] are the transfer ID.
- R2: A fragment of n bytes copies ceil(n/4) consecutive words from its buffer into the current destination buffer, in order.
- R3: Fragments with gather set are packed back to back, by whole words, into one destination buffer. The transfer closes only after a fragment with gather clear, and the written-back length is the sum of all fragment byte counts.
- R4: When a fragment's swap flag is set, each of its words is written with its four bytes in reverse order. Otherwise each word is written unchanged.
- R5: On closing, word 1 of the destination descriptor becomes {ID[13:0], swap, 1'b0, length[15:0]}, where ID and swap are taken from the closing fragment.
- R6: Destination words at byte offset MAX_BYTES or beyond are not written. When the total length exceeds MAX_BYTES, len_err pulses in the same cycle as copy_done.
- R7: The read indices advance by exactly one per fragment or per buffer, modulo 2^IDXW, and stop at the matching write index.
- R8: With a source fragment pending and no posted destination buffer, the engine waits: it advances no index, writes nothing and loses nothing. It proceeds once a buffer is posted. A gather transfer whose next fragment is not yet posted also waits.
- R9: A halt request is honoured only between descriptors. While parked, halted is 1 and the source read index holds. Work resumes when the request drops.
- R10: copy_done is a one-cycle pulse, issued once per destination buffer (not per fragment), in the same cycle the destination read index increments.
- R11: After reset both read indices are 0 and copy_done, len_err, halted and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_base | input | AW | Word address of source ring (even) |
| dst_base | input | AW | Word address of destination ring (even) |
| src_wr_idx | input | IDXW | Software write index of source ring |
| dst_wr_idx | input | IDXW | Software write index of destination ring |
| halt_req | input | 1 | Request to park at the next descriptor boundary |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| src_rd_idx | output | IDXW | Source ring read index |
| dst_rd_idx | output | IDXW | Destination ring read index |
| copy_done | output | 1 | Pulse per finished destination buffer |
| len_err | output | 1 | Maximum-length violation, with copy_done |
| halted | output | 1 | Engine parked by halt request |

## Verification
The destination read index and copy_done change on the same edge, at the end of the descriptor write-back. The bench therefore waits on the index, then lets two more cycles pass before it reads the pulse counters and the memory, so the counter update from that pulse has landed. halted rises on the edge after halt_req is seen in an idle cycle, and the bench samples it three falling edges after driving the request. Stall and mid-gather waits are checked after a fixed wait of tens of cycles, which is longer than any fetch sequence, so an index that should hold has had every chance to move.

// File: rtl/ce_pkg.sv
package ce_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SA, S_SB, S_SC, S_DA, S_RD, S_WR, S_FRAG, S_WB, S_HALT
  } ce_state_e;

  localparam int FLAG_GATHER = 0;
  localparam int FLAG_SWAP   = 1;
  localparam int ID_LSB      = 2;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/ce_ring_ptr.sv
module ce_ring_ptr #(
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [IDXW-1:0] wr_idx,
  output logic [IDXW-1:0] rd_idx,
  output logic            pending
);
  always_ff @(posedge clk) begin
    if (rst) rd_idx <= '0;
    else if (adv) rd_idx <= rd_idx + 1'b1;
  end
  assign pending = (rd_idx != wr_idx);
endmodule

// File: rtl/ce_word_path.sv
module ce_word_path #(
  parameter int MAX_WORDS = 8
) (
  input  logic [31:0] rd_word,
  input  logic        swap,
  input  logic [15:0] off,
  output logic [31:0] wr_word,
  output logic        in_range
);
  import ce_pkg::*;
  assign wr_word  = swap ? bswap32(rd_word) : rd_word;
  assign in_range = (off < 16'(MAX_WORDS));
endmodule

// File: rtl/ce_copy_engine.sv
module ce_copy_engine #(
  parameter int AW        = 16,
  parameter int IDXW      = 3,
  parameter int MAX_BYTES = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   dst_base,
  input  logic [IDXW-1:0] src_wr_idx,
  input  logic [IDXW-1:0] dst_wr_idx,
  input  logic            halt_req,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic [IDXW-1:0] src_rd_idx,
  output logic [IDXW-1:0] dst_rd_idx,
  output logic            copy_done,
  output logic            len_err,
  output logic            halted
);
  import ce_pkg::*;

  localparam int MAX_WORDS = MAX_BYTES / 4;
  localparam int NRING     = 2;   // 0 = source, 1 = destination

  ce_state_e state, state_n;

  logic [AW-1:0]   src_addr_w, dst_addr_w;
  logic [15:0]     nwords, cnt, off;
  logic [16:0]     total;
  logic [15:0]     fl_last;
  logic            in_gather;
  logic [15:0]     nw_in;
  logic [31:0]     xf_word;
  logic            xf_in_range;

  logic [NRING-1:0]  ring_adv, ring_pend;
  logic [IDXW-1:0]   ring_wr [NRING];
  logic [IDXW-1:0]   ring_rd [NRING];

  assign ring_wr[0] = src_wr_idx;
  assign ring_wr[1] = dst_wr_idx;
  assign ring_adv[0] = (state == S_FRAG);
  assign ring_adv[1] = (state == S_WB);

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    ce_ring_ptr #(.IDXW(IDXW)) u_ptr (
      .clk(clk), .rst(rst), .adv(ring_adv[g]), .wr_idx(ring_wr[g]),
      .rd_idx(ring_rd[g]), .pending(ring_pend[g])
    );
  end

  assign src_rd_idx = ring_rd[0];
  assign dst_rd_idx = ring_rd[1];

  ce_word_path #(.MAX_WORDS(MAX_WORDS)) u_path (
    .rd_word(mem_rdata), .swap(fl_last[FLAG_SWAP]), .off(off),
    .wr_word(xf_word), .in_range(xf_in_range)
  );

  assign nw_in = 16'((17'(mem_rdata[15:0]) + 17'd3) >> 2);

  logic [AW-1:0] src_slot, dst_slot;
  assign src_slot = src_base + AW'({ring_rd[0], 1'b0});
  assign dst_slot = dst_base + AW'({ring_rd[1], 1'b0});

  // next state and memory port
  always_comb begin
    state_n   = state;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_IDLE: begin
        if (halt_req) state_n = S_HALT;
        else if (ring_pend[0] && (in_gather || ring_pend[1])) state_n = S_SA;
      end
      S_SA: begin
        mem_req = 1'b1; mem_addr = src_slot; state_n = S_SB;
      end
      S_SB: begin
        mem_req = 1'b1; mem_addr = src_slot + 1'b1; state_n = S_SC;
      end
      S_SC: begin
        if (!in_gather) begin
          mem_req = 1'b1; mem_addr = dst_slot; state_n = S_DA;
        end else begin
          state_n = (nw_in == 16'd0) ? S_FRAG : S_RD;
        end
      end
      S_DA: state_n = (nwords == 16'd0) ? S_FRAG : S_RD;
      S_RD: begin
        mem_req = 1'b1; mem_addr = src_addr_w + AW'(cnt); state_n = S_WR;
      end
      S_WR: begin
        mem_req   = xf_in_range;
        mem_we    = 1'b1;
        mem_addr  = dst_addr_w + AW'(off);
        mem_wdata = xf_word;
        state_n   = (cnt + 16'd1 == nwords) ? S_FRAG : S_RD;
      end
      S_FRAG: state_n = fl_last[FLAG_GATHER] ? S_IDLE : S_WB;
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_slot + 1'b1;
        mem_wdata = {fl_last[15:ID_LSB], fl_last[FLAG_SWAP], 1'b0, total[15:0]};
        state_n   = S_IDLE;
      end
      S_HALT: if (!halt_req) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      src_addr_w <= '0;
      dst_addr_w <= '0;
      nwords     <= '0;
      cnt        <= '0;
      off        <= '0;
      total      <= '0;
      fl_last    <= '0;
      in_gather  <= 1'b0;
      copy_done  <= 1'b0;
      len_err    <= 1'b0;
      halted     <= 1'b0;
    end else begin
      state     <= state_n;
      copy_done <= (state == S_WB);
      len_err   <= (state == S_WB) && (total > 17'(MAX_BYTES));
      halted    <= (state_n == S_HALT);
      case (state)
        S_SB: src_addr_w <= AW'(mem_rdata >> 2);
        S_SC: begin
          nwords  <= nw_in;
          cnt     <= '0;
          fl_last <= mem_rdata[31:16];
          if (in_gather) total <= total + 17'(mem_rdata[15:0]);
          else begin
            total <= 17'(mem_rdata[15:0]);
            off   <= '0;
          end
        end
        S_DA: begin
          dst_addr_w <= AW'(mem_rdata >> 2);
          in_gather  <= 1'b1;
        end
        S_WR: begin
          cnt <= cnt + 16'd1;
          off <= off + 16'd1;
        end
        S_WB: in_gather <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ce_copy_engine_chk.sv
module ce_copy_engine_chk #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [IDXW-1:0] src_rd_idx,
  input logic [IDXW-1:0] dst_rd_idx,
  input logic [IDXW-1:0] dst_wr_idx,
  input logic            copy_done,
  input logic            len_err,
  input logic            halted
);
  assert_src_step_R7: assert property (@(posedge clk) disable iff (rst)
    (src_rd_idx != $past(src_rd_idx)) |-> (src_rd_idx == IDXW'($past(src_rd_idx) + 1'b1)));

  assert_dst_posted_R8: assert property (@(posedge clk) disable iff (rst)
    (dst_rd_idx != $past(dst_rd_idx)) |-> ($past(dst_rd_idx) != $past(dst_wr_idx)));

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(src_rd_idx));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    copy_done |=> !copy_done);

  assert_done_adv_R10: assert property (@(posedge clk) disable iff (rst)
    copy_done |-> (dst_rd_idx == IDXW'($past(dst_rd_idx) + 1'b1)));

  assert_lenerr_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    len_err |-> copy_done);
endmodule

bind ce_copy_engine ce_copy_engine_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .src_rd_idx(src_rd_idx), .dst_rd_idx(dst_rd_idx),
  .dst_wr_idx(dst_wr_idx), .copy_done(copy_done), .len_err(len_err),
  .halted(halted)
);

// File: tb/tb_ce_copy_engine.sv
module tb_ce_copy_engine;
  localparam int AW = 8, IDXW = 3, MAXB = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [IDXW-1:0] src_wr_idx = '0, dst_wr_idx = '0;
  logic halt_req = 1'b0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [IDXW-1:0] src_rd_idx, dst_rd_idx;
  logic copy_done, len_err, halted;

  ce_copy_engine #(.AW(AW), .IDXW(IDXW), .MAX_BYTES(MAXB)) dut (
    .clk(clk), .rst(rst), .src_base(8'd0), .dst_base(8'd16),
    .src_wr_idx(src_wr_idx), .dst_wr_idx(dst_wr_idx), .halt_req(halt_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .src_rd_idx(src_rd_idx), .dst_rd_idx(dst_rd_idx),
    .copy_done(copy_done), .len_err(len_err), .halted(halted)
  );

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  int vec = 0, bad = 0, cd_cnt = 0, le_cnt = 0, cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (!rst && copy_done) cd_cnt++;
    if (!rst && len_err)   le_cnt++;
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  function automatic logic [31:0] pat(int i);
    return 32'h10203040 + 32'(i) * 32'h01030507;
  endfunction
  function automatic logic [31:0] bs(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] sent(int slot, int i);
    return 32'hEE000000 | 32'(slot << 8) | 32'(i);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] exp_buf [16];
  int exp_off, exp_total, exp_cd = 0, exp_le = 0, cur_slot;
  logic [15:0] exp_flags;
  logic [IDXW-1:0] sw_src = '0, sw_dst = '0;

  task automatic begin_xfer();
    cur_slot = int'(sw_dst);
    exp_off = 0; exp_total = 0;
    for (int i = 0; i < 16; i++) exp_buf[i] = sent(cur_slot, i);
  endtask

  task automatic post_dst();
    int s;
    @(negedge clk);
    s = int'(sw_dst);
    mem[16 + 2*s] = 32'((128 + 16*s) * 4);
    mem[17 + 2*s] = 32'h0;
    for (int i = 0; i < 16; i++) mem[128 + 16*s + i] = sent(s, i);
    sw_dst = sw_dst + 1'b1;
    dst_wr_idx = sw_dst;
  endtask

  task automatic post_frag(int srcw, int n, bit g, bit sw, int id);
    int s, nw;
    @(negedge clk);
    s = int'(sw_src);
    mem[2*s]     = 32'(srcw * 4);
    mem[2*s + 1] = {14'(id), sw, g, 16'(n)};
    nw = (n + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      if (exp_off < 8) exp_buf[exp_off] = sw ? bs(pat(srcw - 64 + k)) : pat(srcw - 64 + k);
      exp_off++;
    end
    exp_total += n;
    exp_flags = {14'(id), sw, 1'b0};
    sw_src = sw_src + 1'b1;
    src_wr_idx = sw_src;
  endtask

  task automatic finish_xfer(string req);
    int t = 0;
    while (dst_rd_idx != sw_dst && t < 3000) begin @(negedge clk); t++; end
    check(t < 3000, "R8 completion", 32'(dst_rd_idx), 32'(sw_dst));
    exp_cd++;
    if (exp_total > MAXB) exp_le++;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++)
      check(mem[128 + 16*cur_slot + i] == exp_buf[i], req, mem[128 + 16*cur_slot + i], exp_buf[i]);
    check(mem[17 + 2*cur_slot] == {exp_flags, 16'(exp_total)}, "R5 writeback",
          mem[17 + 2*cur_slot], {exp_flags, 16'(exp_total)});
    check(cd_cnt == exp_cd, "R10 copy_done count", 32'(cd_cnt), 32'(exp_cd));
    check(le_cnt == exp_le, "R6 len_err count", 32'(le_cnt), 32'(exp_le));
    check(src_rd_idx == sw_src, "R7 src index", 32'(src_rd_idx), 32'(sw_src));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 64; i++) mem[64 + i] = pat(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(src_rd_idx == 0, "R11 src_rd_idx", 32'(src_rd_idx), 0);
    check(dst_rd_idx == 0, "R11 dst_rd_idx", 32'(dst_rd_idx), 0);
    check({copy_done, len_err, halted, mem_req} == 4'b0, "R11 outputs",
          32'({copy_done, len_err, halted, mem_req}), 0);

    // R1 R2 R4 R7: single-fragment sweep over lengths, swap and wrap
    for (int t = 0; t < 12; t++) begin
      begin_xfer();
      post_dst();
      post_frag(64 + 4*t, 1 + 3*t, 1'b0, t[0], t * 1117);
      finish_xfer(t[0] ? "R4 swapped copy" : "R2 plain copy");
    end

    // R3: gather of three fragments, with a mid-gather wait
    begin_xfer();
    post_dst();
    post_frag(70, 8, 1'b1, 1'b0, 5);
    repeat (40) @(negedge clk);
    check(dst_rd_idx != sw_dst, "R3 open gather holds buffer", 32'(dst_rd_idx), 32'(sw_dst - 1'b1));
    check(cd_cnt == exp_cd, "R10 no pulse per fragment", 32'(cd_cnt), 32'(exp_cd));
    post_frag(80, 12, 1'b1, 1'b1, 6);
    post_frag(90, 4, 1'b0, 1'b0, 16'h3ABC);
    finish_xfer("R3 gather data");

    // R6: gathered total beyond the maximum
    begin_xfer();
    post_dst();
    post_frag(100, 20, 1'b1, 1'b1, 1);
    post_frag(110, 20, 1'b0, 1'b0, 2);
    finish_xfer("R6 clipped data");

    // R8: source pending, no destination buffer posted
    begin_xfer();
    post_frag(64, 16, 1'b0, 1'b0, 9);
    repeat (50) @(negedge clk);
    check(src_rd_idx == IDXW'(sw_src - 1'b1), "R8 stall src index", 32'(src_rd_idx), 32'(sw_src - 1'b1));
    check(cd_cnt == exp_cd, "R8 stall no completion", 32'(cd_cnt), 32'(exp_cd));
    post_dst();
    finish_xfer("R8 data after stall");

    // R9: halt while idle, then release
    halt_req = 1'b1;
    repeat (3) @(negedge clk);
    check(halted == 1'b1, "R9 halted", 32'(halted), 1);
    begin_xfer();
    post_dst();
    post_frag(72, 12, 1'b0, 1'b1, 77);
    repeat (40) @(negedge clk);
    check(src_rd_idx == IDXW'(sw_src - 1'b1), "R9 src index held", 32'(src_rd_idx), 32'(sw_src - 1'b1));
    check(halted == 1'b1, "R9 still halted", 32'(halted), 1);
    halt_req = 1'b0;
    repeat (3) @(negedge clk);
    check(halted == 1'b0, "R9 released", 32'(halted), 0);
    finish_xfer("R9 data after halt");

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule